// File: doc/BRIEF.md
# Per-Lane Input Sampling Delay

This block sits between the input pads and the read path of a quad or octal serial memory controller. It retimes each of nine read-side input lanes (eight data lines and one data strobe) so that the sampling point can be tuned after silicon, board and temperature effects are known. Each lane has two settings: a 3-bit mode and a 4-bit delay count N. The mode either passes the lane straight through or sends it through a shift chain N+1 stages deep. The chain is clocked on a chosen edge of the core clock, or on a chosen edge of the bus clock followed by one retiming stage on a chosen core-clock edge.

Software writes the nine mode fields as one 32-bit word through a write-enable/data port and can read that word back. The nine delay counts are loaded through a second, 36-bit write port. The bus clock is expected to be a synchronous integer division of the core clock. A setting change acts on the next core-clock rising edge. The chains are not flushed, so for up to N+2 cycles after a change the lane may still show samples taken under the old setting.

Top module: `lane_dly_top`

## Requirements
- R1: Lane i (i = 0..7 data, 8 = strobe) takes its mode from mode-word bits [3i+2:3i], so the strobe uses bits [26:24]. Lanes behave independently.
- R2: Reading the mode word returns bits [26:0] exactly as last written and zeros in bits [31:27].
- R3: Reset (rstN low, asynchronous) clears the mode word and all counts, so every lane comes out of reset in pass-through mode.
- R4: Mode 0 passes the lane input to its output in the same instant, with no clocked stage.
- R5: Mode 1 changes the output at the (N+1)-th core-clock falling edge after the input changes.
- R6: Modes 2 and 3 take N+1 bus-clock rising edges. The output then changes at the first core-clock edge strictly after that: a rising edge for mode 2, a falling edge for mode 3.
- R7: Modes 4 and 5 take N+1 bus-clock falling edges. The output then changes at the first core-clock edge strictly after that: a rising edge for mode 4, a falling edge for mode 5.
- R8: Mode codes 6 and 7 behave exactly like mode 0.
- R9: Lane i takes its delay count N from count-port bits [4i+3:4i]. Every value from 0 to 15 is honoured.
- R10: A lane whose input does not change shows no change on its output, whatever the other lanes do.
- R11: A write with the enable high takes effect at the next core-clock rising edge. With the enable low, the word is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Controller core clock |
| busClk | input | 1 | Bus clock, a synchronous integer division of coreClk |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Mode-word write enable |
| cfgWdata | input | 32 | Mode-word write data |
| cfgRdata | output | 32 | Mode-word read data |
| cntWe | input | 1 | Delay-count write enable |
| cntWdata | input | 36 | Nine 4-bit delay counts, lane i at bits [4i+3:4i] |
| laneIn | input | 9 | Lane inputs from the pads, bit 8 is the strobe |
| laneOut | output | 9 | Retimed lane outputs |

## Verification
The assertions assume that the write ports and lane inputs are driven away from core-clock edges. They also assume that the bus clock only changes just after a core-clock rising edge, so that a bus edge coinciding with a core edge is never captured by the core-side stage at that same edge. The pass-through check further assumes that a lane input is steady across the sampling edge. The stimulus meets these assumptions by driving every input one nanosecond after a core-clock edge and by deriving the bus clock as a divide-by-two toggled from the core-clock rising edge. Each lane step is issued only after the chains have had enough cycles to settle on the new mode and count, so every measured latency belongs to a single, known setting.

// File: rtl/lane_dly_pkg.sv
package lane_dly_pkg;
  localparam int NUM_LANES = 9;
  localparam int MODE_W    = 3;
  localparam int CNT_W     = 4;
  localparam int DEPTH     = 1 << CNT_W;
  localparam int CFG_W     = 32;
  localparam int USED_W    = NUM_LANES * MODE_W;
  localparam int CNT_BUS_W = NUM_LANES * CNT_W;
  localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((64'd1 << USED_W) - 64'd1);

  // Mode codes (6 and 7 fall back to pass-through)
  localparam logic [MODE_W-1:0] M_PASS      = 3'd0;
  localparam logic [MODE_W-1:0] M_CORE_FALL = 3'd1;
  localparam logic [MODE_W-1:0] M_BR_CR     = 3'd2;
  localparam logic [MODE_W-1:0] M_BR_CF     = 3'd3;
  localparam logic [MODE_W-1:0] M_BF_CR     = 3'd4;
  localparam logic [MODE_W-1:0] M_BF_CF     = 3'd5;

  // Control strobes handed from the control module to the datapath
  typedef struct packed {
    logic             bypass;     // straight through
    logic             coreTap;    // use the core-falling chain
    logic             busFall;    // bus chain on falling bus edge
    logic             finalFall;  // retime stage on falling core edge
    logic [CNT_W-1:0] count;      // tap index N
  } laneCtl_t;
endpackage

// File: rtl/lane_dly_ctrl.sv
module lane_dly_ctrl
  import lane_dly_pkg::*;
(
  input  logic                             coreClk,
  input  logic                             rstN,
  input  logic                             cfgWe,
  input  logic [CFG_W-1:0]                 cfgWdata,
  input  logic                             cntWe,
  input  logic [CNT_BUS_W-1:0]             cntWdata,
  output logic [CFG_W-1:0]                 cfgRdata,
  output laneCtl_t [NUM_LANES-1:0]         laneCtl
);
  logic [USED_W-1:0]    modeReg;
  logic [CNT_BUS_W-1:0] cntReg;

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (cfgWe) begin
      modeReg <= cfgWdata[USED_W-1:0];
    end
  end

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (cntWe) begin
      cntReg <= cntWdata;
    end
  end

  assign cfgRdata = {{(CFG_W-USED_W){1'b0}}, modeReg};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
    logic [MODE_W-1:0] laneMode;
    assign laneMode = modeReg[g*MODE_W +: MODE_W];

    always_comb begin
      laneCtl[g]           = '0;
      laneCtl[g].count     = cntReg[g*CNT_W +: CNT_W];
      case (laneMode)
        M_CORE_FALL: laneCtl[g].coreTap = 1'b1;
        M_BR_CR:     ;
        M_BR_CF:     laneCtl[g].finalFall = 1'b1;
        M_BF_CR:     laneCtl[g].busFall = 1'b1;
        M_BF_CF: begin
          laneCtl[g].busFall   = 1'b1;
          laneCtl[g].finalFall = 1'b1;
        end
        default:     laneCtl[g].bypass = 1'b1;  // 0, 6, 7
      endcase
    end
  end
endmodule

// File: rtl/lane_dly_path.sv
module lane_dly_path
  import lane_dly_pkg::*;
(
  input  logic                     coreClk,
  input  logic                     busClk,
  input  logic                     rstN,
  input  laneCtl_t [NUM_LANES-1:0] laneCtl,
  input  logic [NUM_LANES-1:0]     laneIn,
  output logic [NUM_LANES-1:0]     laneOut
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DEPTH-1:0] coreFallSr;
    logic [DEPTH-1:0] busRiseSr;
    logic [DEPTH-1:0] busFallSr;
    logic             busTap;
    logic             retimeRise;
    logic             retimeFall;

    always_ff @(negedge coreClk or negedge rstN) begin
      if (!rstN) coreFallSr <= '0;
      else       coreFallSr <= {coreFallSr[DEPTH-2:0], laneIn[g]};
    end

    always_ff @(posedge busClk or negedge rstN) begin
      if (!rstN) busRiseSr <= '0;
      else       busRiseSr <= {busRiseSr[DEPTH-2:0], laneIn[g]};
    end

    always_ff @(negedge busClk or negedge rstN) begin
      if (!rstN) busFallSr <= '0;
      else       busFallSr <= {busFallSr[DEPTH-2:0], laneIn[g]};
    end

    assign busTap = laneCtl[g].busFall ? busFallSr[laneCtl[g].count]
                                       : busRiseSr[laneCtl[g].count];

    always_ff @(posedge coreClk or negedge rstN) begin
      if (!rstN) retimeRise <= 1'b0;
      else       retimeRise <= busTap;
    end

    always_ff @(negedge coreClk or negedge rstN) begin
      if (!rstN) retimeFall <= 1'b0;
      else       retimeFall <= busTap;
    end

    always_comb begin
      if (laneCtl[g].bypass)         laneOut[g] = laneIn[g];
      else if (laneCtl[g].coreTap)   laneOut[g] = coreFallSr[laneCtl[g].count];
      else if (laneCtl[g].finalFall) laneOut[g] = retimeFall;
      else                           laneOut[g] = retimeRise;
    end
  end
endmodule

// File: rtl/lane_dly_top.sv
module lane_dly_top
  import lane_dly_pkg::*;
(
  input  logic                 coreClk,
  input  logic                 busClk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_W-1:0]     cfgWdata,
  output logic [CFG_W-1:0]     cfgRdata,
  input  logic                 cntWe,
  input  logic [CNT_BUS_W-1:0] cntWdata,
  input  logic [NUM_LANES-1:0] laneIn,
  output logic [NUM_LANES-1:0] laneOut
);
  laneCtl_t [NUM_LANES-1:0] laneCtl;

  lane_dly_ctrl u_ctrl (
    .coreClk  (coreClk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cntWe    (cntWe),
    .cntWdata (cntWdata),
    .cfgRdata (cfgRdata),
    .laneCtl  (laneCtl)
  );

  lane_dly_path u_path (
    .coreClk (coreClk),
    .busClk  (busClk),
    .rstN    (rstN),
    .laneCtl (laneCtl),
    .laneIn  (laneIn),
    .laneOut (laneOut)
  );
endmodule

// File: rtl/lane_dly_checker.sv
module lane_dly_checker
  import lane_dly_pkg::*;
(
  input logic                 coreClk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [CFG_W-1:0]     cfgWdata,
  input logic [CFG_W-1:0]     cfgRdata,
  input logic [NUM_LANES-1:0] laneIn,
  input logic [NUM_LANES-1:0] laneOut
);
  // R2: unused bits always read as zero
  a_r2_spare_zero: assert property (@(posedge coreClk) disable iff (!rstN)
    cfgRdata[CFG_W-1:USED_W] == '0);

  // R3: while reset is held the mode word reads zero
  a_r3_reset_clear: assert property (@(posedge coreClk)
    !rstN |-> cfgRdata == '0);

  // R11: an enabled write is visible after the next rising edge
  a_r11_write_lands: assert property (@(posedge coreClk) disable iff (!rstN)
    cfgWe |=> cfgRdata == ($past(cfgWdata) & CFG_MASK));

  // R11: without an enable the word holds
  a_r11_no_write_holds: assert property (@(posedge coreClk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgRdata));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pass
    logic [MODE_W-1:0] md;
    assign md = cfgRdata[g*MODE_W +: MODE_W];
    // R4, R8: pass-through codes follow the input
    a_r4_pass_follows: assert property (@(posedge coreClk) disable iff (!rstN)
      (md == 3'd0 || md == 3'd6 || md == 3'd7) |-> laneOut[g] == laneIn[g]);
  end
endmodule

bind lane_dly_top lane_dly_checker u_chk (
  .coreClk  (coreClk),
  .rstN     (rstN),
  .cfgWe    (cfgWe),
  .cfgWdata (cfgWdata),
  .cfgRdata (cfgRdata),
  .laneIn   (laneIn),
  .laneOut  (laneOut)
);

// File: tb/lane_dly_top_bench.sv
`timescale 1ns/100ps
module lane_dly_top_bench;
  localparam int NL = 9;

  logic        coreClk = 1'b0;
  logic        busClk  = 1'b0;
  logic        rstN    = 1'b0;
  logic        cfgWe   = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        cntWe   = 1'b0;
  logic [35:0] cntWdata = '0;
  logic [8:0]  laneIn  = '0;
  logic [8:0]  laneOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  lane_dly_top u_lane_dly_top (
    .coreClk, .busClk, .rstN, .cfgWe, .cfgWdata, .cfgRdata,
    .cntWe, .cntWdata, .laneIn, .laneOut
  );

  // 200 MHz core clock; rising edges at 2.5 + 5k ns
  always #2.5 coreClk = ~coreClk;
  // bus clock = core / 2, toggled just after each core rising edge
  always @(posedge coreClk) busClk <= ~busClk;

  // ---------------- scoreboard ----------------
  typedef struct {
    int     lane;
    longint expT;   // 0.1 ns units, -1 = no change expected
    string  req;
  } item_t;
  item_t sbq[$];

  bit      armed = 0;
  bit      seen [NL];
  longint  seenT[NL];
  logic [8:0] prevOut = 'x;
  bit      reqCheck = 0;

  function automatic longint nowT();
    return longint'($realtime * 10.0);
  endfunction

  // n-th edge (phase + period*k) strictly after t
  function automatic longint nthEdge(longint t, longint phase, longint period, int n);
    longint k;
    k = (t < phase) ? 0 : ((t - phase) / period) + 1;
    return phase + (k + n - 1) * period;
  endfunction

  // Reference latency model from the requirements (0.1 ns units)
  // core rise 25+50k, core fall 50k, bus rise 25+100k, bus fall 75+100k
  function automatic longint expectT(int md, int n, longint t0);
    longint tb;
    case (md)
      1: return nthEdge(t0, 50, 50, n + 1);
      2: begin tb = nthEdge(t0, 25, 100, n + 1); return nthEdge(tb, 25, 50, 1); end
      3: begin tb = nthEdge(t0, 25, 100, n + 1); return nthEdge(tb, 50, 50, 1); end
      4: begin tb = nthEdge(t0, 75, 100, n + 1); return nthEdge(tb, 25, 50, 1); end
      5: begin tb = nthEdge(t0, 75, 100, n + 1); return nthEdge(tb, 50, 50, 1); end
      default: return t0;
    endcase
  endfunction

  function automatic string reqOf(int md);
    case (md)
      0: return "R4";
      1: return "R5 R9";
      2, 3: return "R6 R9";
      4, 5: return "R7 R9";
      default: return "R8";
    endcase
  endfunction

  // monitor: record first output change per lane while armed
  always @(laneOut) begin
    for (int i = 0; i < NL; i++) begin
      if (armed && !seen[i] && laneOut[i] !== prevOut[i]) begin
        seen[i]  = 1'b1;
        seenT[i] = nowT();
      end
    end
    prevOut = laneOut;
  end

  // monitor: pop and compare queued expectations
  initial begin
    forever begin
      wait (reqCheck);
      while (sbq.size() > 0) begin
        item_t it;
        longint got;
        it  = sbq.pop_front();
        got = seen[it.lane] ? seenT[it.lane] : -1;
        nChecks++;
        if (got != it.expT) begin
          nFails++;
          $display("FAIL %s lane %0d: output change at %0d, expected %0d (0.1ns units)",
                   it.req, it.lane, got, it.expT);
        end
      end
      reqCheck = 0;
    end
  end

  task automatic check(string req, longint act, longint exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic writeCfg(logic [31:0] v);
    @(negedge coreClk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge coreClk);
    cfgWe = 1'b0;
  endtask

  task automatic writeCnt(logic [35:0] v);
    @(negedge coreClk);
    cntWe = 1'b1; cntWdata = v;
    @(negedge coreClk);
    cntWe = 1'b0;
  endtask

  // driver: program all lanes, step masked lanes, queue expectations
  task automatic runTest(input int md[NL], input int cn[NL],
                         input logic [8:0] mask, input bit afterFall);
    logic [31:0] mw;
    logic [35:0] cw;
    longint t0;
    mw = '0; cw = '0;
    for (int i = 0; i < NL; i++) begin
      mw[3*i +: 3] = 3'(md[i]);
      cw[4*i +: 4] = 4'(cn[i]);
    end
    writeCfg(mw);
    writeCnt(cw);
    repeat (45) @(posedge coreClk);
    if (afterFall) @(negedge coreClk);
    else           @(posedge coreClk);
    #1;
    for (int i = 0; i < NL; i++) seen[i] = 1'b0;
    armed = 1'b1;
    t0 = nowT();
    laneIn = laneIn ^ mask;
    for (int i = 0; i < NL; i++) begin
      item_t it;
      it.lane = i;
      if (mask[i]) begin
        it.expT = expectT(md[i], cn[i], t0);
        it.req  = reqOf(md[i]);
      end else begin
        it.expT = -1;
        it.req  = "R10";
      end
      sbq.push_back(it);
    end
    repeat (45) @(posedge coreClk);
    #1;
    armed = 1'b0;
    check("R1", longint'(laneOut), longint'(laneIn), "settled lanes");
    reqCheck = 1;
    wait (!reqCheck);
  endtask

  // watchdog
  initial begin
    #1000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int md[NL];
    int cn[NL];

    laneIn = 9'h1A5;
    repeat (4) @(posedge coreClk);
    #1;
    // R3: reset state
    check("R3", longint'(cfgRdata), 0, "mode word in reset");
    @(negedge coreClk);
    rstN = 1'b1;
    repeat (3) @(posedge coreClk);
    #1;
    check("R3", longint'(cfgRdata), 0, "mode word after reset");
    check("R3", longint'(laneOut), longint'(9'h1A5), "pass-through after reset");
    laneIn = 9'h05A;
    #0.2;
    check("R4", longint'(laneOut), longint'(9'h05A), "instant follow after reset");

    // R2 / R11: readback and write timing
    @(negedge coreClk);
    cfgWe = 1'b1; cfgWdata = 32'hFFFF_FFFF;
    #0.5;
    check("R11", longint'(cfgRdata), 0, "before write edge");
    @(negedge coreClk);
    cfgWe = 1'b0;
    check("R2", longint'(cfgRdata), longint'(32'h07FF_FFFF), "readback all ones");
    cfgWdata = 32'h0123_4567;
    repeat (2) @(negedge coreClk);
    check("R11", longint'(cfgRdata), longint'(32'h07FF_FFFF), "no write without enable");
    writeCfg(32'hF2B6_D3A1);
    check("R2", longint'(cfgRdata), longint'(32'h02B6_D3A1), "readback pattern");

    // all pass-through
    for (int i = 0; i < NL; i++) begin md[i] = 0; cn[i] = 7; end
    runTest(md, cn, 9'h1FF, 0);
    // core-falling chain, N = 0 and N = 15
    for (int i = 0; i < NL; i++) begin md[i] = 1; cn[i] = 0; end
    runTest(md, cn, 9'h1FF, 1);
    for (int i = 0; i < NL; i++) begin md[i] = 1; cn[i] = 15; end
    runTest(md, cn, 9'h0AA, 0);
    // bus chains at the count extremes
    for (int i = 0; i < NL; i++) begin md[i] = 2; cn[i] = 0; end
    runTest(md, cn, 9'h155, 1);
    for (int i = 0; i < NL; i++) begin md[i] = 5; cn[i] = 15; end
    runTest(md, cn, 9'h1FF, 0);
    // R1 R9: rotating per-lane modes and counts
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < NL; i++) begin
        md[i] = (k + i) % 8;
        cn[i] = (k * 5 + i * 3) % 16;
      end
      runTest(md, cn, (k % 3 == 0) ? 9'h1FF : ((k % 3 == 1) ? 9'h0F3 : 9'h10C), k[0]);
    end
    // R8: reserved codes
    for (int i = 0; i < NL; i++) begin md[i] = 6 + (i % 2); cn[i] = 9; end
    runTest(md, cn, 9'h1FF, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule